// File: doc/BRIEF.md
# System Register Store and Trap Execution Unit

This unit executes one slice of a small 32-bit processor's instruction set. It handles the instructions that copy a control register, a multiply-accumulate half, the procedure return register or one of eight banked registers into a general register. It also handles the variants that push one of these onto a stack with a pre-decremented pointer, and the software trap. A 16-bit instruction word arrives with a valid strobe and is accepted whenever the unit is not busy. The pointer register is read from the general register file through a combinational read port. Results go back through a one-cycle write port.

A push issues a single-beat 32-bit write on a request/ready port. The pointer update to Rn minus 4 is written back only in the cycle the memory accepts the write. The trap saves the instruction's PC and the status register, records the scaled immediate, and after a fixed sequence redirects the program counter to the vector base plus 0x100. The rest of the core updates the system registers through a write port and reads them through a registered read port. Encodings outside the handled family raise a one-cycle illegal flag.

Top module: `sru_top`

## Requirements
- R1: A word of the form 0000nnnn ffff 0010 copies a control register into Rn: f=0000 SR, 0001 GBR, 0010 VBR, 0011 SSR, 0100 SPC, and f=1mmm banked register m. The write appears on the register write port (we, Rn, value) in the cycle after acceptance, for one cycle. SR is left unchanged.
- R2: A word 0000nnnn 00ss 1010 with ss=00 MACH, 01 MACL, 10 PR copies that register into Rn in the same way as R1.
- R3: A word 0100nnnn ffff 0011 (f coded as in R1), or 0100nnnn 00ss 0010 (ss coded as in R2), raises a memory write request in the cycle after acceptance. Its address is Rn-4, wrapping modulo 2^32, and its data is the selected register.
- R4: While the request is high and ready is low, address, data and request hold steady and no register write occurs. On the cycle after the edge where request and ready are both high, the request drops and Rn is written with the address.
- R5: busy is high while a memory write waits or a trap runs. A valid instruction presented while busy has no effect.
- R6: A trap 11000011 iiiiiiii copies the instruction PC to SPC and SR to SSR. It loads TRA with the immediate shifted left by 2, zero in bits 31:10 and 1:0.
- R7: After a trap is accepted, busy stays high for 7 cycles. redirect_valid then pulses for exactly one cycle with redirect_pc = VBR + 0x100, and busy is low in that cycle.
- R8: Any other encoding pulses illegal for one cycle with no register write, no memory request, busy low and SR unchanged.
- R9: When a system-register write targets SSR in the same cycle a trap is accepted, the trap's save wins. When it targets SR in that cycle, SR takes the written value and SSR receives the SR value from before that edge.
- R10: The system read port returns the selected register one cycle after the select is applied. Select codes are SR 0, GBR 1, VBR 2, SSR 3, SPC 4, MACH 5, MACL 6, PR 7, TRA 8 and bank m at 16+m.
- R11: After synchronous reset every system register reads zero, and request, register write, redirect, illegal and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 16 | Instruction encoding |
| instr_pc | input | 32 | PC of the presented instruction |
| busy | output | 1 | Unit cannot accept an instruction |
| illegal | output | 1 | One-cycle pulse for an unhandled encoding |
| gpr_raddr | output | 4 | General register read index (word bits 11:8) |
| gpr_rdata | input | 32 | General register read data |
| gpr_we | output | 1 | General register write enable |
| gpr_waddr | output | 4 | General register write index |
| gpr_wdata | output | 32 | General register write data |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the write |
| redirect_valid | output | 1 | PC redirect pulse |
| redirect_pc | output | 32 | Redirect target |
| sys_wr_en | input | 1 | System register write strobe |
| sys_wr_sel | input | 5 | System register write select (R10 codes) |
| sys_wr_data | input | 32 | System register write data |
| sys_rd_sel | input | 5 | System register read select (R10 codes) |
| sys_rd_data | output | 32 | Registered system register read data |

## Verification
Two functions meet in one edge: the trap's save of PC and SR, and an external write through the system-register port. The bench applies a sys write in the same cycle it presents the trap word, once aimed at SSR and once at SR. It then reads SSR, SR, SPC and TRA back through the read port. The first case must show the trap's saved value in SSR. The second must show the new SR with the old SR in SSR. A pointer write-back competing with a new instruction during a stalled push is also provoked, and judged by the absence of any register write until ready.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam int SEL_W      = 5;
  localparam int SLOT_SPACE = 1 << SEL_W;
  localparam int IDX_SR     = 0;
  localparam int IDX_GBR    = 1;
  localparam int IDX_VBR    = 2;
  localparam int IDX_SSR    = 3;
  localparam int IDX_SPC    = 4;
  localparam int IDX_MACH   = 5;
  localparam int IDX_MACL   = 6;
  localparam int IDX_PR     = 7;
  localparam int IDX_TRA    = 8;
  localparam int BANK_BASE  = 16;
  localparam int BANK_COUNT = 8;

  typedef enum logic [1:0] {OP_BAD, OP_COPY, OP_PUSH, OP_TRAP} op_e;

  typedef struct packed {
    op_e              op;
    logic [3:0]       rn;
    logic [SEL_W-1:0] src;
    logic [7:0]       imm;
  } dec_t;
endpackage

// File: rtl/sru_decode.sv
module sru_decode
  import sru_pkg::*;
(
  input  logic [15:0] word,
  output dec_t        dec
);
  logic             ctrl_ok, sys_ok;
  logic [SEL_W-1:0] ctrl_src, sys_src;

  always_comb begin
    ctrl_ok  = word[7] | (word[7:4] <= 4'd4);
    ctrl_src = word[7] ? (SEL_W'(BANK_BASE) | SEL_W'(word[6:4])) : SEL_W'(word[7:4]);
    sys_ok   = (word[7:6] == 2'b00) && (word[5:4] != 2'b11);
    sys_src  = SEL_W'(IDX_MACH) + SEL_W'(word[5:4]);
    dec      = '0;
    dec.op   = OP_BAD;
    dec.rn   = word[11:8];
    dec.imm  = word[7:0];
    if (word[15:12] == 4'h0 && word[3:0] == 4'h2 && ctrl_ok) begin
      dec.op  = OP_COPY;
      dec.src = ctrl_src;
    end else if (word[15:12] == 4'h0 && word[3:0] == 4'hA && sys_ok) begin
      dec.op  = OP_COPY;
      dec.src = sys_src;
    end else if (word[15:12] == 4'h4 && word[3:0] == 4'h3 && ctrl_ok) begin
      dec.op  = OP_PUSH;
      dec.src = ctrl_src;
    end else if (word[15:12] == 4'h4 && word[3:0] == 4'h2 && sys_ok) begin
      dec.op  = OP_PUSH;
      dec.src = sys_src;
    end else if (word[15:8] == 8'hC3) begin
      dec.op  = OP_TRAP;
    end
  end
endmodule

// File: rtl/sru_sysregs.sv
module sru_sysregs
  import sru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             trap_save,
  input  logic [XLEN-1:0]  save_pc,
  input  logic [7:0]       save_imm,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [XLEN-1:0]  rd_data,
  input  logic [SEL_W-1:0] mon_sel,
  output logic [XLEN-1:0]  mon_data,
  output logic [XLEN-1:0]  vbr
);
  logic [XLEN-1:0] slot_val [SLOT_SPACE];
  logic [XLEN-1:0] tra_next;

  assign tra_next = {{(XLEN-10){1'b0}}, save_imm, 2'b00};

  for (genvar i = 0; i < SLOT_SPACE; i++) begin : g_slot
    if (i <= IDX_TRA || (i >= BANK_BASE && i < BANK_BASE + BANK_COUNT)) begin : g_live
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (trap_save && i == IDX_SPC) q <= save_pc;
        else if (trap_save && i == IDX_SSR) q <= slot_val[IDX_SR];
        else if (trap_save && i == IDX_TRA) q <= tra_next;
        else if (wr_en && wr_sel == SEL_W'(i)) q <= wr_data;
      end
      assign slot_val[i] = q;
    end else begin : g_hole
      assign slot_val[i] = '0;
    end
  end

  assign rd_data = slot_val[rd_sel];
  assign vbr     = slot_val[IDX_VBR];

  always_ff @(posedge clk) begin
    if (rst) mon_data <= '0;
    else     mon_data <= slot_val[mon_sel];
  end

  // R6
  tra_shape_chk: assert property (@(posedge clk) disable iff (rst)
    trap_save |=> (slot_val[IDX_TRA][1:0] == 2'b00 && slot_val[IDX_TRA][XLEN-1:10] == '0));
  // R9
  ssr_save_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_save && wr_en && wr_sel == SEL_W'(IDX_SSR)) |=> slot_val[IDX_SSR] == $past(slot_val[IDX_SR]));
endmodule

// File: rtl/sru_trap_seq.sv
module sru_trap_seq #(
  parameter int              XLEN        = 32,
  parameter int              TRAP_CYCLES = 8,
  parameter logic [XLEN-1:0] VEC_OFFSET  = 'h100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [XLEN-1:0] vbr,
  output logic            active,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc
);
  localparam int CNT_W = $clog2(TRAP_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q          <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      redirect_valid <= 1'b0;
      if (start) begin
        cnt_q <= CNT_W'(TRAP_CYCLES - 1);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          redirect_valid <= 1'b1;
          redirect_pc    <= vbr + VEC_OFFSET;
        end
      end
    end
  end

  assign active = (cnt_q != '0);

  // R7
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> !redirect_valid);
  // R7
  redirect_idle_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> (!active && $past(active)));
  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> active);
endmodule

// File: rtl/sru_top.sv
module sru_top
  import sru_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              TRAP_CYCLES = 8,
  parameter logic [XLEN-1:0] VEC_OFFSET  = 'h100,
  parameter logic [XLEN-1:0] PUSH_STEP   = 'd4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [15:0]      instr_word,
  input  logic [XLEN-1:0]  instr_pc,
  output logic             busy,
  output logic             illegal,
  output logic [3:0]       gpr_raddr,
  input  logic [XLEN-1:0]  gpr_rdata,
  output logic             gpr_we,
  output logic [3:0]       gpr_waddr,
  output logic [XLEN-1:0]  gpr_wdata,
  output logic             mem_req,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic             mem_ready,
  output logic             redirect_valid,
  output logic [XLEN-1:0]  redirect_pc,
  input  logic             sys_wr_en,
  input  logic [SEL_W-1:0] sys_wr_sel,
  input  logic [XLEN-1:0]  sys_wr_data,
  input  logic [SEL_W-1:0] sys_rd_sel,
  output logic [XLEN-1:0]  sys_rd_data
);
  dec_t            dec;
  logic            accept, trap_start, trap_active;
  logic [XLEN-1:0] src_val, vbr;
  logic [3:0]      pend_rn;

  sru_decode u_dec (.word(instr_word), .dec(dec));

  assign accept     = instr_valid && !busy;
  assign trap_start = accept && dec.op == OP_TRAP;
  assign busy       = mem_req || trap_active;
  assign gpr_raddr  = instr_word[11:8];

  sru_sysregs #(.XLEN(XLEN)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(sys_wr_en), .wr_sel(sys_wr_sel), .wr_data(sys_wr_data),
    .trap_save(trap_start), .save_pc(instr_pc), .save_imm(dec.imm),
    .rd_sel(dec.src), .rd_data(src_val),
    .mon_sel(sys_rd_sel), .mon_data(sys_rd_data),
    .vbr(vbr)
  );

  sru_trap_seq #(.XLEN(XLEN), .TRAP_CYCLES(TRAP_CYCLES), .VEC_OFFSET(VEC_OFFSET)) u_trap (
    .clk(clk), .rst(rst), .start(trap_start), .vbr(vbr),
    .active(trap_active), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gpr_we    <= 1'b0;
      gpr_waddr <= '0;
      gpr_wdata <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      pend_rn   <= '0;
      illegal   <= 1'b0;
    end else begin
      gpr_we  <= 1'b0;
      illegal <= 1'b0;
      if (mem_req) begin
        if (mem_ready) begin
          mem_req   <= 1'b0;
          gpr_we    <= 1'b1;
          gpr_waddr <= pend_rn;
          gpr_wdata <= mem_addr;
        end
      end else if (accept) begin
        case (dec.op)
          OP_COPY: begin
            gpr_we    <= 1'b1;
            gpr_waddr <= dec.rn;
            gpr_wdata <= src_val;
          end
          OP_PUSH: begin
            mem_req   <= 1'b1;
            mem_addr  <= gpr_rdata - PUSH_STEP;
            mem_wdata <= src_val;
            pend_rn   <= dec.rn;
          end
          OP_BAD:  illegal <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && !gpr_we));
  // R5
  req_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(!busy));
  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!gpr_we && !mem_req && !busy));
  // R8
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |=> !illegal);
endmodule

// File: tb/sru_top_tb_top.sv
module sru_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_word = '0;
  logic [31:0] instr_pc = '0;
  logic        busy, illegal, gpr_we, mem_req, redirect_valid;
  logic [3:0]  gpr_raddr, gpr_waddr;
  logic [31:0] gpr_rdata, gpr_wdata, mem_addr, mem_wdata, redirect_pc, sys_rd_data;
  logic        mem_ready = 1'b1;
  logic        sys_wr_en = 1'b0;
  logic [4:0]  sys_wr_sel = '0;
  logic [31:0] sys_wr_data = '0;
  logic [4:0]  sys_rd_sel = '0;

  logic [31:0] gpr_m [16];
  logic        preset_en = 1'b0;
  logic [3:0]  preset_idx = '0;
  logic [31:0] preset_val = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sru_top dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .instr_pc(instr_pc), .busy(busy), .illegal(illegal), .gpr_raddr(gpr_raddr),
    .gpr_rdata(gpr_rdata), .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .sys_wr_en(sys_wr_en), .sys_wr_sel(sys_wr_sel), .sys_wr_data(sys_wr_data),
    .sys_rd_sel(sys_rd_sel), .sys_rd_data(sys_rd_data)
  );

  assign gpr_rdata = gpr_m[gpr_raddr];

  always @(posedge clk) begin
    if (preset_en) gpr_m[preset_idx] <= preset_val;
    else if (gpr_we) gpr_m[gpr_waddr] <= gpr_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic set_gpr(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk); preset_en = 1'b1; preset_idx = idx; preset_val = val;
    @(negedge clk); preset_en = 1'b0;
  endtask

  task automatic sys_write(input logic [4:0] sel, input logic [31:0] val);
    @(negedge clk); sys_wr_en = 1'b1; sys_wr_sel = sel; sys_wr_data = val;
    @(negedge clk); sys_wr_en = 1'b0;
  endtask

  task automatic sys_read(input logic [4:0] sel, output logic [31:0] val);
    @(negedge clk); sys_rd_sel = sel;
    @(negedge clk); val = sys_rd_data;
  endtask

  task automatic issue(input logic [15:0] w, input logic [31:0] pc);
    @(negedge clk); instr_valid = 1'b1; instr_word = w; instr_pc = pc;
    @(negedge clk); instr_valid = 1'b0;
  endtask

  function automatic logic [31:0] seed(input int sel);
    return 32'hA500_0000 + 32'(sel) * 32'h0001_0111;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    chk_eq("R11 busy", {31'b0, busy}, 32'd0);
    chk_eq("R11 mem_req", {31'b0, mem_req}, 32'd0);
    chk_eq("R11 gpr_we", {31'b0, gpr_we}, 32'd0);
    chk_eq("R11 redirect", {31'b0, redirect_valid}, 32'd0);
    chk_eq("R11 illegal", {31'b0, illegal}, 32'd0);
    sys_read(5'd2, v);  chk_eq("R11 VBR zero", v, 32'd0);
    sys_read(5'd19, v); chk_eq("R11 bank3 zero", v, 32'd0);
  endtask

  task automatic t_load_regs();
    logic [31:0] v;
    for (int s = 0; s < 8; s++) sys_write(5'(s), seed(s));
    for (int m = 0; m < 8; m++) sys_write(5'(16 + m), seed(16 + m));
    sys_read(5'd6, v);  chk_eq("R10 MACL readback", v, seed(6));
    sys_read(5'd21, v); chk_eq("R10 bank5 readback", v, seed(21));
  endtask

  task automatic t_copy_ctrl();
    logic [31:0] v;
    issue(16'h03D2, 32'h0);
    chk_eq("R1 bank5 we", {31'b0, gpr_we}, 32'd1);
    chk_eq("R1 bank5 idx", {28'b0, gpr_waddr}, 32'd3);
    chk_eq("R1 bank5 data", gpr_wdata, seed(21));
    issue(16'h0E22, 32'h0);
    chk_eq("R1 VBR idx", {28'b0, gpr_waddr}, 32'd14);
    chk_eq("R1 VBR data", gpr_wdata, seed(2));
    @(negedge clk);
    chk_eq("R1 single cycle we", {31'b0, gpr_we}, 32'd0);
    issue(16'h0142, 32'h0);
    chk_eq("R1 SPC data", gpr_wdata, seed(4));
    sys_read(5'd0, v); chk_eq("R1 SR unchanged", v, seed(0));
  endtask

  task automatic t_copy_sys();
    issue(16'h071A, 32'h0);
    chk_eq("R2 MACL idx", {28'b0, gpr_waddr}, 32'd7);
    chk_eq("R2 MACL data", gpr_wdata, seed(6));
    issue(16'h020A, 32'h0);
    chk_eq("R2 MACH data", gpr_wdata, seed(5));
    issue(16'h092A, 32'h0);
    chk_eq("R2 PR data", gpr_wdata, seed(7));
  endtask

  task automatic t_push_fast();
    set_gpr(4'd4, 32'h0000_1000);
    mem_ready = 1'b1;
    issue(16'h4413, 32'h0);
    chk_eq("R3 req", {31'b0, mem_req}, 32'd1);
    chk_eq("R3 addr", mem_addr, 32'h0000_0FFC);
    chk_eq("R3 GBR data", mem_wdata, seed(1));
    chk_eq("R5 busy during req", {31'b0, busy}, 32'd1);
    @(negedge clk);
    chk_eq("R4 req dropped", {31'b0, mem_req}, 32'd0);
    chk_eq("R4 wb we", {31'b0, gpr_we}, 32'd1);
    chk_eq("R4 wb idx", {28'b0, gpr_waddr}, 32'd4);
    chk_eq("R4 wb data", gpr_wdata, 32'h0000_0FFC);
    @(negedge clk);
    chk_eq("R4 Rn model", gpr_m[4], 32'h0000_0FFC);
    set_gpr(4'd1, 32'h0);
    issue(16'h41A3, 32'h0);
    chk_eq("R3 wrap addr", mem_addr, 32'hFFFF_FFFC);
    chk_eq("R3 bank2 data", mem_wdata, seed(18));
    @(negedge clk);
  endtask

  task automatic t_push_stall();
    set_gpr(4'd6, 32'h0000_2000);
    set_gpr(4'd10, 32'h0000_ABCD);
    mem_ready = 1'b0;
    issue(16'h4622, 32'h0);
    chk_eq("R3 PR push data", mem_wdata, seed(7));
    issue(16'h0AD2, 32'h0);
    chk_eq("R5 ignored while busy", {31'b0, gpr_we}, 32'd0);
    chk_eq("R4 held req", {31'b0, mem_req}, 32'd1);
    chk_eq("R4 held addr", mem_addr, 32'h0000_1FFC);
    @(negedge clk);
    chk_eq("R4 Rn untouched in stall", gpr_m[6], 32'h0000_2000);
    mem_ready = 1'b1;
    @(negedge clk);
    chk_eq("R4 wb after ready", {31'b0, gpr_we}, 32'd1);
    chk_eq("R4 wb idx after ready", {28'b0, gpr_waddr}, 32'd6);
    @(negedge clk);
    chk_eq("R4 Rn after ready", gpr_m[6], 32'h0000_1FFC);
    chk_eq("R5 ignored copy left R10", gpr_m[10], 32'h0000_ABCD);
  endtask

  task automatic run_trap(input logic [7:0] imm, input logic [31:0] pc, input logic [4:0] csel,
                          input logic [31:0] cval, input logic [31:0] vbr_v);
    @(negedge clk);
    instr_valid = 1'b1; instr_word = {8'hC3, imm}; instr_pc = pc;
    sys_wr_en = 1'b1; sys_wr_sel = csel; sys_wr_data = cval;
    @(negedge clk);
    instr_valid = 1'b0; sys_wr_en = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk(busy === 1'b1 && redirect_valid === 1'b0, "R7 busy window", {31'b0, busy}, 32'd1);
    end
    @(negedge clk);
    chk_eq("R7 redirect valid", {31'b0, redirect_valid}, 32'd1);
    chk_eq("R7 redirect pc", redirect_pc, vbr_v + 32'h100);
    chk_eq("R7 busy low at redirect", {31'b0, busy}, 32'd0);
    @(negedge clk);
    chk_eq("R7 redirect one cycle", {31'b0, redirect_valid}, 32'd0);
  endtask

  task automatic t_trap_ssr_clash();
    logic [31:0] v;
    sys_write(5'd0, 32'h0000_00F3);
    sys_write(5'd2, 32'h8000_0000);
    run_trap(8'hA5, 32'h0000_1234, 5'd3, 32'hDEAD_BEEF, 32'h8000_0000);
    sys_read(5'd3, v); chk_eq("R9 SSR save wins", v, 32'h0000_00F3);
    sys_read(5'd4, v); chk_eq("R6 SPC", v, 32'h0000_1234);
    sys_read(5'd8, v); chk_eq("R6 TRA", v, 32'h0000_0294);
  endtask

  task automatic t_trap_sr_clash();
    logic [31:0] v;
    sys_write(5'd2, 32'hFFFF_FF80);
    run_trap(8'hFF, 32'h0C00_0010, 5'd0, 32'h0000_0055, 32'hFFFF_FF80);
    sys_read(5'd0, v); chk_eq("R9 SR new value", v, 32'h0000_0055);
    sys_read(5'd3, v); chk_eq("R9 SSR old SR", v, 32'h0000_00F3);
    sys_read(5'd8, v); chk_eq("R6 TRA zero extend", v, 32'h0000_03FC);
    sys_read(5'd4, v); chk_eq("R6 SPC second", v, 32'h0C00_0010);
  endtask

  task automatic t_illegal();
    logic [15:0] bad [4];
    logic [31:0] v;
    bad[0] = 16'h4553; bad[1] = 16'h003A; bad[2] = 16'hC400; bad[3] = 16'h0052;
    for (int i = 0; i < 4; i++) begin
      issue(bad[i], 32'h0);
      chk(illegal === 1'b1 && gpr_we === 1'b0 && mem_req === 1'b0 && busy === 1'b0,
          "R8 illegal quiet", {28'b0, illegal, gpr_we, mem_req, busy}, 32'h8);
      @(negedge clk);
      chk_eq("R8 illegal one cycle", {31'b0, illegal}, 32'd0);
    end
    sys_read(5'd0, v); chk_eq("R8 SR unchanged", v, 32'h0000_0055);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) gpr_m[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_regs();
    t_copy_ctrl();
    t_copy_sys();
    t_push_fast();
    t_push_stall();
    t_trap_ssr_clash();
    t_trap_sr_clash();
    t_illegal();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule